// File: doc/BRIEF.md
# Queue Error Interrupt and Enable Control

This block holds the per-queue status, interrupt-enable and run-enable state of one instruction queue. Five event sources raise sticky status flags: mailbox, doorbell overflow, instruction read error, result write error and engine software error. Software clears the flags with write-1-to-clear and can also raise them with write-1-to-set through a separate address. A second register holds one interrupt enable per flag. It has its own set and clear addresses. The interrupt output is asserted while any flag and its enable are both high.

Three of the flags stop the queue: doorbell overflow, instruction read error and result write error. When one of them is raised and continue-on-error is off, the queue run-enable is cleared. This holds whether a hardware pulse or a software set-write raises the flag. When continue-on-error is on, these errors leave the queue running. An 8-bit in-flight counter tracks the instructions that have been fetched but not yet retired. Software polls it, after clearing the run-enable, before it reconfigures the queue.

The register port is a single-cycle write strobe with a 3-bit address. Read data is combinational from the current register state.

Top module: `qerr_irq_ctrl`

## Requirements
- R1: After reset, every readable address returns 0, `queue_en_o` is 0 and `irq_o` is 0.
- R2: A high bit of `evt_i` in a cycle sets the matching status bit at that clock edge, and the bit stays set until it is cleared. Bit order from bit 0 is: mailbox, doorbell overflow, instruction read error, result write error, engine software error. Address 0 and address 1 both read the status in bits 4:0.
- R3: A write to address 0 clears each status bit whose `wdata_i` bit is 1. Zero bits have no effect. An event on the same bit in the same cycle wins over the clear.
- R4: A write to address 1 sets each status bit whose `wdata_i` bit is 1.
- R5: A write to address 2 sets interrupt-enable bits and a write to address 3 clears them, in both cases where `wdata_i` is 1. Both addresses read the enables in bits 4:0, in the same bit order as the status.
- R6: `irq_o` is 1 exactly when some status bit and its enable bit are both 1. It follows the registered state, so it changes one cycle after the causing edge.
- R7: While continue-on-error is 0, raising status bit 1, 2 or 3, by event or by a write to address 1, clears the queue run-enable at that edge. This also wins over a control write in the same cycle. Bits 0 and 4 never affect the run-enable.
- R8: While continue-on-error is 1, error flags leave the queue run-enable unchanged.
- R9: Address 4 is read/write control. Bit 0 is the queue run-enable, which drives `queue_en_o`. Bit 1 is continue-on-error. The halt decision of R7 uses the continue-on-error value held before the write.
- R10: Address 5 reads the in-flight count. It increments on `fetch_i`, decrements on `retire_i`, and is unchanged when both or neither are high. It holds at 255 on an increment and at 0 on a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | Hardware event pulses, one per status bit |
| fetch_i | input | 1 | Instruction fetch issued |
| retire_i | input | 1 | Instruction result completed |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| queue_en_o | output | 1 | Queue run-enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences test each status write against an event on the same bit in the same cycle. This separates a design where the clear wins from one where the event wins. Errors are raised in both continue-on-error settings, together with a control write in the same cycle, to check the R7 priority and the R8 exemption. Mailbox and engine-error flags are raised to show that they never halt the queue. The counter is driven past both of its limits and pulsed with simultaneous fetch and retire. After that, a long random mix of events, writes to all eight addresses and counter pulses is compared every cycle against a bench model of the requirements. This exposes swapped bit positions, wrong alias decoding and lost updates.

// File: rtl/qerr_pkg.sv
package qerr_pkg;
  localparam int NSRC = 5;
  localparam int SRC_MBOX  = 0;
  localparam int SRC_DBOVF = 1;
  localparam int SRC_RDERR = 2;
  localparam int SRC_WRERR = 3;
  localparam int SRC_SWERR = 4;
  localparam logic [NSRC-1:0] HALT_MASK =
    NSRC'((1 << SRC_DBOVF) | (1 << SRC_RDERR) | (1 << SRC_WRERR));

  typedef enum logic [2:0] {
    A_STAT     = 3'd0,
    A_STAT_SET = 3'd1,
    A_IEN_SET  = 3'd2,
    A_IEN_CLR  = 3'd3,
    A_CTL      = 3'd4,
    A_INFL     = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/qerr_sticky.sv
module qerr_sticky #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[b] <= 1'b0;
      else if (set_i[b])  q_o[b] <= 1'b1;  // set beats clear
      else if (clr_i[b])  q_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/qerr_qen.sv
module qerr_qen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [1:0] ctl_wd_i,
  input  logic       halt_req_i,
  output logic       qen_o,
  output logic       cont_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qen_o      <= 1'b0;
      cont_err_o <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        qen_o      <= ctl_wd_i[0];
        cont_err_o <= ctl_wd_i[1];
      end
      // halt uses the mode held before this edge and overrides the write
      if (halt_req_i && !cont_err_o) qen_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qerr_inflight.sv
module qerr_inflight #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && !dec_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    else if (dec_i && !inc_i && cnt_o != '0)      cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/qerr_irq_ctrl.sv
module qerr_irq_ctrl
  import qerr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int AW    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            fetch_i,
  input  logic            retire_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            queue_en_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] AD_STAT  = AW'(A_STAT);
  localparam logic [AW-1:0] AD_SSET  = AW'(A_STAT_SET);
  localparam logic [AW-1:0] AD_ESET  = AW'(A_IEN_SET);
  localparam logic [AW-1:0] AD_ECLR  = AW'(A_IEN_CLR);
  localparam logic [AW-1:0] AD_CTL   = AW'(A_CTL);
  localparam logic [AW-1:0] AD_INFL  = AW'(A_INFL);

  logic [NSRC-1:0]  wbits;
  logic [NSRC-1:0]  st_set, st_clr, en_set, en_clr;
  logic [NSRC-1:0]  status_q, ien_q;
  logic             cont_err_q;
  logic [CNT_W-1:0] infl_q;

  assign wbits  = wdata_i[NSRC-1:0];
  assign st_set = evt_i | ((wr_i && addr_i == AD_SSET) ? wbits : '0);
  assign st_clr = (wr_i && addr_i == AD_STAT) ? wbits : '0;
  assign en_set = (wr_i && addr_i == AD_ESET) ? wbits : '0;
  assign en_clr = (wr_i && addr_i == AD_ECLR) ? wbits : '0;

  qerr_sticky #(.W(NSRC)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(st_set), .clr_i(st_clr), .q_o(status_q)
  );

  qerr_sticky #(.W(NSRC)) u_ien (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set), .clr_i(en_clr), .q_o(ien_q)
  );

  qerr_qen u_qen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (wr_i && addr_i == AD_CTL),
    .ctl_wd_i   (wdata_i[1:0]),
    .halt_req_i (|(st_set & HALT_MASK)),
    .qen_o      (queue_en_o),
    .cont_err_o (cont_err_q)
  );

  qerr_inflight #(.CNT_W(CNT_W)) u_infl (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fetch_i), .dec_i(retire_i), .cnt_o(infl_q)
  );

  assign irq_o = |(status_q & ien_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AD_STAT, AD_SSET: rdata_o = DW'(status_q);
      AD_ESET, AD_ECLR: rdata_o = DW'(ien_q);
      AD_CTL:           rdata_o = DW'({cont_err_q, queue_en_o});
      AD_INFL:          rdata_o = DW'(infl_q);
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/qerr_irq_ctrl_chk.sv
module qerr_irq_ctrl_chk
  import qerr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int AW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NSRC-1:0]  evt_i,
  input logic             fetch_i,
  input logic             retire_i,
  input logic             wr_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             queue_en_o,
  input logic             irq_o,
  input logic [NSRC-1:0]  status_q,
  input logic [NSRC-1:0]  ien_q,
  input logic             cont_err_q,
  input logic [CNT_W-1:0] infl_q
);
  p_evt_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(A_STAT) && evt_i == '0)
      |=> ((status_q & $past(wdata_i[NSRC-1:0])) == '0));

  p_w1s_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(A_STAT_SET))
      |=> ((status_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_err_q && (|(evt_i & HALT_MASK))) |=> !queue_en_o);

  p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_err_q && queue_en_o && !(wr_i && addr_i == AW'(A_CTL))) |=> queue_en_o);

  p_cnt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_i == retire_i) |=> $stable(infl_q));

  p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (infl_q == '1 && fetch_i && !retire_i) |=> $stable(infl_q));
endmodule

bind qerr_irq_ctrl qerr_irq_ctrl_chk #(.DW(DW), .CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .fetch_i    (fetch_i),
  .retire_i   (retire_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .queue_en_o (queue_en_o),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .ien_q      (ien_q),
  .cont_err_q (cont_err_q),
  .infl_q     (infl_q)
);

// File: tb/qerr_irq_ctrl_tb_top.sv
module qerr_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [4:0] evt;
  logic       fetch, retire, wr;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       qen, irq;

  always #4 clk = ~clk;  // 125 MHz

  qerr_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .fetch_i(fetch), .retire_i(retire),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .queue_en_o(qen), .irq_o(irq)
  );

  int  checks = 0, errs = 0;
  bit  finished = 0;
  logic [4:0] st_m, en_m;
  logic       qen_m, ce_m;
  logic [7:0] cnt_m;

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return {3'b0, st_m};
      3'd2, 3'd3: return {3'b0, en_m};
      3'd4:       return {6'b0, ce_m, qen_m};
      3'd5:       return cnt_m;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2 status read";
      3'd2, 3'd3: return "R5 enable read";
      3'd4:       return "R9 control read";
      3'd5:       return "R10 count read";
      default:    return "R1 unmapped read";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(logic [4:0] e, logic f, logic r, logic w,
                            logic [2:0] a, logic [7:0] d);
    logic [4:0] set, clr;
    logic       ce_old;
    set    = e | ((w && a == 3'd1) ? d[4:0] : 5'b0);
    clr    = (w && a == 3'd0) ? d[4:0] : 5'b0;
    st_m   = (st_m & ~clr) | set;
    if (w && a == 3'd2) en_m = en_m | d[4:0];
    if (w && a == 3'd3) en_m = en_m & ~d[4:0];
    ce_old = ce_m;
    if (w && a == 3'd4) begin qen_m = d[0]; ce_m = d[1]; end
    if (!ce_old && |(set & 5'b01110)) qen_m = 1'b0;
    if (f && !r && cnt_m != 8'hFF) cnt_m = cnt_m + 8'd1;
    else if (r && !f && cnt_m != 8'h00) cnt_m = cnt_m - 8'd1;
  endtask

  // drive at negedge, check outputs before the edge, then advance the model
  task automatic step(logic [4:0] e, logic f, logic r, logic w,
                      logic [2:0] a, logic [7:0] d, string tag);
    evt = e; fetch = f; retire = r; wr = w; addr = a; wdata = d;
    #1;
    chk({tag, " / ", tag_of(a)}, rdata, exp_read(a));
    chk({tag, " / R6 irq"}, {7'b0, irq}, {7'b0, |(st_m & en_m)});
    chk({tag, " / R7 queue enable"}, {7'b0, qen}, {7'b0, qen_m});
    @(posedge clk);
    model_edge(e, f, r, w, a, d);
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    step(5'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    st_m = '0; en_m = '0; qen_m = 0; ce_m = 0; cnt_m = '0;
    rst_ni = 0; evt = '0; fetch = 0; retire = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset");

    step(5'b0, 0, 0, 1, 3'd4, 8'h01, "R9 enable queue");
    rd(3'd4, "R9");
    step(5'b00001, 0, 0, 0, 3'd0, 8'h00, "R2 mailbox event");
    rd(3'd0, "R2");  // mailbox set, queue still enabled (R7)
    step(5'b10000, 0, 0, 0, 3'd0, 8'h00, "R2 engine error event");
    rd(3'd1, "R2");
    step(5'b0, 0, 0, 1, 3'd0, 8'h01, "R3 clear mailbox");
    rd(3'd0, "R3");
    step(5'b10000, 0, 0, 1, 3'd0, 8'h10, "R3 event beats clear");
    rd(3'd0, "R3");
    chk("R3 engine bit kept", rdata, 8'h10);
    step(5'b0, 0, 0, 1, 3'd0, 8'h00, "R3 zero write");
    rd(3'd0, "R3");
    step(5'b0, 0, 0, 1, 3'd1, 8'h04, "R4 set read error");
    rd(3'd0, "R4");
    chk("R7 software set halts", {7'b0, qen}, 8'h00);
    step(5'b0, 0, 0, 1, 3'd2, 8'h1F, "R5 enable all");
    rd(3'd2, "R6 irq on");
    step(5'b0, 0, 0, 1, 3'd3, 8'h1B, "R5 clear some");
    rd(3'd3, "R5");
    step(5'b0, 0, 0, 1, 3'd0, 8'h1F, "R6 clear status");
    rd(3'd3, "R6 irq off");
    step(5'b0, 0, 0, 1, 3'd4, 8'h03, "R8 cont-on-error");
    step(5'b01110, 0, 0, 0, 3'd4, 8'h00, "R8 errors");
    rd(3'd4, "R8");
    chk("R8 queue stays on", {7'b0, qen}, 8'h01);
    step(5'b0, 0, 0, 1, 3'd4, 8'h01, "R9 back to halt mode");
    step(5'b01000, 0, 0, 1, 3'd4, 8'h01, "R7 halt beats write");
    rd(3'd4, "R7");
    chk("R7 write-error halt", {7'b0, qen}, 8'h00);

    for (int i = 0; i < 260; i++) step(5'b0, 1, 0, 0, 3'd5, 8'h00, "R10 fill");
    rd(3'd5, "R10");
    chk("R10 saturate high", rdata, 8'hFF);
    step(5'b0, 1, 1, 0, 3'd5, 8'h00, "R10 both");
    for (int i = 0; i < 260; i++) step(5'b0, 0, 1, 0, 3'd5, 8'h00, "R10 drain");
    rd(3'd5, "R10");
    chk("R10 saturate low", rdata, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] e;
      e = '0;
      for (int b = 0; b < 5; b++) e[b] = ($urandom % 10) == 0;
      step(e, 1'($urandom), 1'($urandom), ($urandom % 5) < 2,
           3'($urandom), 8'($urandom), "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule